// File: doc/BRIEF.md
# Masked prioritized interrupt controller

This block collects interrupt requests for a small 8-bit processor core and decides which one the core should service next. Six request levels feed a request register. Each level can be set by a rising edge on a hardware request line, after synchronisation, or by software writing the register. A level mask with a global-enable bit, and a one-bit priority-order register, decide which pending level wins. The winner is offered to the core as a request line. When the core acknowledges it, the block latches the winning level as the vector index, clears that request and drops the global enable.

The core supplies decoded enable (EI) and disable (DI) strobes and a register write port, and reads the registers back through a read port. The global enable cannot be turned on by a register write until at least one EI strobe has been seen since the configuration was last cleared. While the global enable is on, the mask and order registers are locked. The reset input comes with a cause code. Only a power-on reset, or a watchdog reset taken while the core was running, returns the configuration to its defaults. A stop-mode recovery reset leaves the configuration in place.

Top module: `irq_ctrl`

## Requirements
- R1: While `rst_n` is low, the request register and `int_vec` clear on every clock edge. The mask, global enable, order bit, arm state and `cfg_err` clear only when `rst_cause` is 0 (power-on), or when it is 1 (watchdog) with `run_mode` high. With cause 2 (stop-mode recovery), or cause 1 with `run_mode` low, they keep their values.
- R2: Until an EI strobe has been seen since the configuration was last cleared, a mask write with bit 7 set leaves the global enable off. Such a write reads back with bit 7 clear and produces no `int_req`.
- R3: An EI strobe turns the global enable on at the next edge. Once an EI has been seen, an accepted mask write with bit 7 set has the same effect.
- R4: A DI strobe turns the global enable off at the next edge. When EI and DI arrive in the same cycle, DI wins.
- R5: A write to the mask register (address 1) or the order register (address 2) while the global enable is on is dropped, and it sets `cfg_err`. `cfg_err` stays set until a configuration-clearing reset.
- R6: Writing address 0 loads the request register from `wr_data[5:0]` at any time. A bit written to 1 is handled exactly like a hardware request. Reads return the register at address 0, the mask at address 1 with bit 7 showing the global enable, the order bit at address 2 in bit 0, and zero at address 3.
- R7: `int_req` is high exactly when the global enable is on and some request bit has its mask bit (mask bits 5:0) set.
- R8: The winner is the lowest-numbered enabled pending level when the order bit is 0, and the highest-numbered when it is 1. `int_vec` gives the winning level number.
- R9: An edge with both `int_ack` and `int_req` high has three effects: it loads `int_vec` with the winner, clears that request bit and turns the global enable off. `int_vec` changes at no other time except reset. `int_ack` without `int_req` has no effect.
- R10: A hardware line that rises sets its request bit at the third clock edge after the rise. A line held high sets the bit only once.
- R11: When a software write to address 0 and a hardware-set pulse land on the same edge, the new request value is the written data ORed with the hardware bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rst_cause | input | 2 | Reset cause: 0 power-on, 1 watchdog, 2 stop-mode recovery |
| run_mode | input | 1 | High when the core was in run mode at the reset |
| hw_irq | input | 6 | Asynchronous hardware request lines, one per level |
| ei_stb | input | 1 | Decoded enable-interrupts strobe |
| di_stb | input | 1 | Decoded disable-interrupts strobe |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 request, 1 mask, 2 order |
| wr_data | input | 8 | Write data |
| rd_addr | input | 2 | Read address, same map |
| rd_data | output | 8 | Read data (combinational) |
| int_req | output | 1 | An enabled request is pending |
| int_vec | output | 3 | Level number of the last acknowledged request |
| int_ack | input | 1 | Core acknowledge |
| cfg_err | output | 1 | Sticky flag for a configuration write while enabled |

## Verification
The bench targets the arming rule first. A design that let a mask write enable interrupts straight after reset would raise `int_req` before any EI. It then checks collisions between strobes: DI with EI, acknowledge with a locked write, and a software request write with a hardware edge. Getting any of these wrong would show as a lost request or as interrupts left enabled. It exercises both priority orders and acknowledges while nothing is pending, to catch a vector that drifts. It also drives every reset cause, because a design that cleared the configuration on stop-mode recovery would read back a zero mask.

// File: rtl/irq_ctrl_pkg.sv
// Shared constants for the interrupt controller: register addresses and
// reset-cause codes. Assumes a 2-bit register address space.
package irq_ctrl_pkg;

    localparam int ADDR_W = 2;

    localparam logic [ADDR_W-1:0] ADR_REQ   = 2'd0;
    localparam logic [ADDR_W-1:0] ADR_MASK  = 2'd1;
    localparam logic [ADDR_W-1:0] ADR_ORDER = 2'd2;

    typedef enum logic [1:0] {
        CAUSE_POR  = 2'd0,
        CAUSE_WDT  = 2'd1,
        CAUSE_SMR  = 2'd2,
        CAUSE_NONE = 2'd3
    } rst_cause_e;

endpackage

// File: rtl/irq_edge_sync.sv
// Synchronises each asynchronous request line through STAGES flops and emits
// a one-cycle pulse on a rising edge of the synchronised value.
// Assumes request lines stay stable for at least one clock when they change.
module irq_edge_sync #(
    parameter int NUM_LVL = 6,
    parameter int STAGES  = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_LVL-1:0] async_in,
    output logic [NUM_LVL-1:0] rise
);

    generate
        for (genvar g = 0; g < NUM_LVL; g++) begin : g_lvl
            logic [STAGES:0] chain;

            // shift the line through the synchroniser plus one history flop
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    chain <= '0;
                end else begin
                    chain <= {chain[STAGES-1:0], async_in[g]};
                end
            end

            assign rise[g] = chain[STAGES-1] & ~chain[STAGES];
        end
    endgenerate

endmodule

// File: rtl/irq_prio_sel.sv
// Picks the winning candidate level. order_hi = 0 lets the lowest-numbered
// level win; order_hi = 1 lets the highest-numbered level win.
// Purely combinational; assumes NUM_LVL <= 2**VEC_W.
module irq_prio_sel #(
    parameter int NUM_LVL = 6,
    parameter int VEC_W   = 3
) (
    input  logic [NUM_LVL-1:0] cand,
    input  logic               order_hi,
    output logic               any,
    output logic [VEC_W-1:0]   idx
);

    // scan levels in the chosen order and keep the first hit
    always_comb begin
        int lvl;
        any = 1'b0;
        idx = '0;
        lvl = 0;
        for (int i = 0; i < NUM_LVL; i++) begin
            lvl = order_hi ? (NUM_LVL - 1 - i) : i;
            if (!any && cand[lvl]) begin
                any = 1'b1;
                idx = VEC_W'(lvl);
            end
        end
    end

endmodule

// File: rtl/irq_req_bank.sv
// Request register, one flop per level. A software write replaces the bits,
// an acknowledge clears the serviced bit, and hardware pulses are ORed in last
// so that a same-cycle hardware event is never lost.
module irq_req_bank #(
    parameter int NUM_LVL = 6,
    parameter int VEC_W   = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sw_wr,
    input  logic [NUM_LVL-1:0] sw_data,
    input  logic               ack_take,
    input  logic [VEC_W-1:0]   ack_idx,
    input  logic [NUM_LVL-1:0] hw_set,
    output logic [NUM_LVL-1:0] req_q
);

    generate
        for (genvar g = 0; g < NUM_LVL; g++) begin : g_bit
            logic base;
            logic drop;

            assign base = sw_wr ? sw_data[g] : req_q[g];
            assign drop = ack_take && (ack_idx == VEC_W'(g));

            // update one request bit: write, then acknowledge clear, then hardware set
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    req_q[g] <= 1'b0;
                end else begin
                    req_q[g] <= (base & ~drop) | hw_set[g];
                end
            end
        end
    endgenerate

endmodule

// File: rtl/irq_cfg_regs.sv
// Mask, global enable, order bit, arm state and configuration error flag.
// Global enable is armed only by an EI strobe; mask and order writes are
// dropped (and flagged) while the global enable is on. On reset the state is
// cleared only when cfg_clr is high; otherwise it holds.
module irq_cfg_regs #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_clr,
    input  logic              ei_stb,
    input  logic              di_stb,
    input  logic              ack_take,
    input  logic              mask_wr,
    input  logic              order_wr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-2:0] mask_q,
    output logic              gie,
    output logic              armed,
    output logic              order_q,
    output logic              cfg_err
);

    localparam int GIE_BIT = DATA_W - 1;

    logic mask_ok;
    logic order_ok;
    logic locked_hit;
    logic gie_d;

    assign mask_ok    = mask_wr && !gie;
    assign order_ok   = order_wr && !gie;
    assign locked_hit = (mask_wr || order_wr) && gie;

    // next global enable: acknowledge, then DI, then EI, then an accepted mask write
    always_comb begin
        if (ack_take) begin
            gie_d = 1'b0;
        end else if (di_stb) begin
            gie_d = 1'b0;
        end else if (ei_stb) begin
            gie_d = 1'b1;
        end else if (mask_ok) begin
            gie_d = armed && wr_data[GIE_BIT];
        end else begin
            gie_d = gie;
        end
    end

    // configuration state; cleared in reset only when the cause allows it
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            if (cfg_clr) begin
                mask_q  <= '0;
                gie     <= 1'b0;
                armed   <= 1'b0;
                order_q <= 1'b0;
                cfg_err <= 1'b0;
            end
        end else begin
            gie <= gie_d;
            if (ei_stb) begin
                armed <= 1'b1;
            end
            if (mask_ok) begin
                mask_q <= wr_data[DATA_W-2:0];
            end
            if (order_ok) begin
                order_q <= wr_data[0];
            end
            if (locked_hit) begin
                cfg_err <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/irq_ctrl.sv
// Masked prioritized interrupt controller top. Latches synchronised hardware
// edges and software writes into a request register, masks them, selects a
// winner in the programmed order, and hands the level number to the core on
// acknowledge. Assumes NUM_LVL < DATA_W so the global enable bit sits above
// the level mask bits.
module irq_ctrl
    import irq_ctrl_pkg::*;
#(
    parameter int NUM_LVL     = 6,
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [1:0]                 rst_cause,
    input  logic                       run_mode,
    input  logic [NUM_LVL-1:0]         hw_irq,
    input  logic                       ei_stb,
    input  logic                       di_stb,
    input  logic                       wr_en,
    input  logic [ADDR_W-1:0]          wr_addr,
    input  logic [DATA_W-1:0]          wr_data,
    input  logic [ADDR_W-1:0]          rd_addr,
    output logic [DATA_W-1:0]          rd_data,
    output logic                       int_req,
    output logic [$clog2(NUM_LVL)-1:0] int_vec,
    input  logic                       int_ack,
    output logic                       cfg_err
);

    localparam int VEC_W   = $clog2(NUM_LVL);
    localparam int GIE_BIT = DATA_W - 1;

    rst_cause_e         cause;
    logic               cfg_clr;
    logic [NUM_LVL-1:0] hw_set;
    logic [NUM_LVL-1:0] req_q;
    logic [DATA_W-2:0]  mask_q;
    logic               gie;
    logic               armed;
    logic               order_q;
    logic [NUM_LVL-1:0] cand;
    logic               sel_any;
    logic [VEC_W-1:0]   sel_idx;
    logic               ack_take;

    assign cause   = rst_cause_e'(rst_cause);
    assign cfg_clr = !rst_n && ((cause == CAUSE_POR) || ((cause == CAUSE_WDT) && run_mode));

    irq_edge_sync #(
        .NUM_LVL (NUM_LVL),
        .STAGES  (SYNC_STAGES)
    ) i_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (hw_irq),
        .rise     (hw_set)
    );

    irq_cfg_regs #(
        .DATA_W (DATA_W)
    ) i_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_clr  (cfg_clr),
        .ei_stb   (ei_stb),
        .di_stb   (di_stb),
        .ack_take (ack_take),
        .mask_wr  (wr_en && (wr_addr == ADR_MASK)),
        .order_wr (wr_en && (wr_addr == ADR_ORDER)),
        .wr_data  (wr_data),
        .mask_q   (mask_q),
        .gie      (gie),
        .armed    (armed),
        .order_q  (order_q),
        .cfg_err  (cfg_err)
    );

    irq_req_bank #(
        .NUM_LVL (NUM_LVL),
        .VEC_W   (VEC_W)
    ) i_req (
        .clk      (clk),
        .rst_n    (rst_n),
        .sw_wr    (wr_en && (wr_addr == ADR_REQ)),
        .sw_data  (wr_data[NUM_LVL-1:0]),
        .ack_take (ack_take),
        .ack_idx  (sel_idx),
        .hw_set   (hw_set),
        .req_q    (req_q)
    );

    assign cand = req_q & mask_q[NUM_LVL-1:0];

    irq_prio_sel #(
        .NUM_LVL (NUM_LVL),
        .VEC_W   (VEC_W)
    ) i_sel (
        .cand     (cand),
        .order_hi (order_q),
        .any      (sel_any),
        .idx      (sel_idx)
    );

    assign int_req  = gie && sel_any;
    assign ack_take = int_ack && int_req;

    // vector index: loaded on an accepted acknowledge, held otherwise
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            int_vec <= '0;
        end else if (ack_take) begin
            int_vec <= sel_idx;
        end
    end

    // register read-back mux
    always_comb begin
        rd_data = '0;
        unique case (rd_addr)
            ADR_REQ:   rd_data[NUM_LVL-1:0] = req_q;
            ADR_MASK: begin
                rd_data[DATA_W-2:0] = mask_q;
                rd_data[GIE_BIT]    = gie;
            end
            ADR_ORDER: rd_data[0] = order_q;
            default:   rd_data = '0;
        endcase
    end

endmodule

// File: rtl/irq_ctrl_chk.sv
// Property checker for irq_ctrl, attached with bind. Observes ports and the
// configuration and request state.
module irq_ctrl_chk
    import irq_ctrl_pkg::*;
#(
    parameter int NUM_LVL = 6,
    parameter int DATA_W  = 8
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       ei_stb,
    input logic                       di_stb,
    input logic                       wr_en,
    input logic [ADDR_W-1:0]          wr_addr,
    input logic                       int_ack,
    input logic                       int_req,
    input logic [$clog2(NUM_LVL)-1:0] int_vec,
    input logic                       cfg_err,
    input logic                       gie,
    input logic                       armed,
    input logic [DATA_W-2:0]          mask_q,
    input logic [NUM_LVL-1:0]         req_q
);

    assert_no_gie_unarmed_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !armed |-> !gie);

    assert_ei_enables_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ei_stb && !di_stb && !(int_ack && int_req)) |=> gie);

    assert_di_disables_R4: assert property (@(posedge clk) disable iff (!rst_n)
        di_stb |=> !gie);

    assert_locked_mask_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_addr == ADR_MASK) && gie) |=> (mask_q == $past(mask_q)));

    assert_err_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |=> cfg_err);

    assert_req_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
        int_req |-> (gie && ((req_q & mask_q[NUM_LVL-1:0]) != '0)));

    assert_vec_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
        int_vec < NUM_LVL);

    assert_vec_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(int_ack && int_req) |=> $stable(int_vec));

    assert_ack_drops_gie_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (int_ack && int_req) |=> !gie);

endmodule

bind irq_ctrl irq_ctrl_chk #(
    .NUM_LVL (NUM_LVL),
    .DATA_W  (DATA_W)
) i_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .ei_stb  (ei_stb),
    .di_stb  (di_stb),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .int_ack (int_ack),
    .int_req (int_req),
    .int_vec (int_vec),
    .cfg_err (cfg_err),
    .gie     (gie),
    .armed   (armed),
    .mask_q  (mask_q),
    .req_q   (req_q)
);

// File: tb/test_irq_ctrl.sv
`timescale 1ns/100ps
module test_irq_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] rst_cause = 2'd0;
    logic       run_mode = 1'b1;
    logic [5:0] hw_irq = '0;
    logic       ei_stb = 1'b0;
    logic       di_stb = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [1:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       int_req;
    logic [2:0] int_vec;
    logic       int_ack = 1'b0;
    logic       cfg_err;

    int total = 0;
    int fails = 0;
    bit done = 0;

    always #2 clk = ~clk;

    irq_ctrl i_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .rst_cause(rst_cause), .run_mode(run_mode),
        .hw_irq(hw_irq), .ei_stb(ei_stb), .di_stb(di_stb), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .int_req(int_req), .int_vec(int_vec), .int_ack(int_ack), .cfg_err(cfg_err)
    );

    // ---------------- behavioural reference model ----------------
    bit [5:0] m_req, m_s1, m_s2, m_s3;
    bit [6:0] m_mask;
    bit       m_gie, m_armed, m_order, m_err;
    int       m_vec;

    function automatic int m_winner();
        for (int i = 0; i < 6; i++) begin
            int lvl = m_order ? 5 - i : i;
            if (m_req[lvl] && m_mask[lvl]) return lvl;
        end
        return 0;
    endfunction

    function automatic bit m_pend();
        return m_gie && ((m_req & m_mask[5:0]) != 0);
    endfunction

    function automatic bit [7:0] m_read(bit [1:0] a);
        case (a)
            2'd0: return {2'b00, m_req};
            2'd1: return {m_gie, m_mask};
            2'd2: return {7'b0, m_order};
            default: return 8'h00;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            if (rst_cause == 2'd0 || (rst_cause == 2'd1 && run_mode)) begin
                m_mask = 0; m_gie = 0; m_armed = 0; m_order = 0; m_err = 0;
            end
            m_req = 0; m_vec = 0; m_s1 = 0; m_s2 = 0; m_s3 = 0;
        end else begin
            bit [5:0] hw_new;
            bit [5:0] nreq;
            bit take, ngie;
            int win;
            hw_new = m_s2 & ~m_s3;
            m_s3 = m_s2; m_s2 = m_s1; m_s1 = hw_irq;
            win  = m_winner();
            take = int_ack && m_pend();
            nreq = (wr_en && wr_addr == 2'd0) ? wr_data[5:0] : m_req;
            if (take) nreq[win] = 1'b0;
            nreq = nreq | hw_new;
            ngie = m_gie;
            if (wr_en && wr_addr == 2'd1) begin
                if (m_gie) m_err = 1;
                else begin m_mask = wr_data[6:0]; ngie = m_armed && wr_data[7]; end
            end
            if (wr_en && wr_addr == 2'd2) begin
                if (m_gie) m_err = 1;
                else m_order = wr_data[0];
            end
            if (ei_stb) begin ngie = 1; m_armed = 1; end
            if (di_stb) ngie = 0;
            if (take) ngie = 0;
            m_gie = ngie;
            m_req = nreq;
            if (take) m_vec = win;
        end
    end

    // per-cycle comparison against the model, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            cmp("R7 int_req", int_req, m_pend());
            cmp("R9 int_vec", int_vec, m_vec);
            cmp("R5 cfg_err", cfg_err, m_err);
            cmp("R6 rd_data", rd_data, m_read(rd_addr));
        end
    end

    task automatic cmp(string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- stimulus helpers ----------------
    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(bit [1:0] a, bit [7:0] d);
        wr_en = 1; wr_addr = a; wr_data = d;
        tick();
        wr_en = 0;
    endtask

    task automatic ei();  ei_stb = 1; tick(); ei_stb = 0; endtask
    task automatic di();  di_stb = 1; tick(); di_stb = 0; endtask
    task automatic ack(); int_ack = 1; tick(); int_ack = 0; endtask

    task automatic rd(bit [1:0] a, output logic [7:0] v);
        rd_addr = a;
        #0.5;
        v = rd_data;
    endtask

    task automatic do_reset(bit [1:0] c, bit run);
        rst_cause = c; run_mode = run; rst_n = 0;
        tick(); tick();
        rst_n = 1;
        tick();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++; fails++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        tick(); tick();
        rst_n = 1;
        tick();

        // R1: power-on reset state
        rd(2'd1, v); cmp("R1 mask after POR", v, 8'h00);
        rd(2'd2, v); cmp("R1 order after POR", v, 8'h00);
        cmp("R1 int_req after POR", int_req, 0);
        cmp("R1 cfg_err after POR", cfg_err, 0);
        cmp("R1 int_vec after POR", int_vec, 0);

        // R2: mask bit 7 before any EI does not enable
        wr(2'd1, 8'hBF);
        rd(2'd1, v); cmp("R2 mask bit7 unarmed", v, 8'h3F);
        wr(2'd0, 8'h04);
        rd(2'd0, v); cmp("R6 software request", v, 8'h04);
        cmp("R2 no int_req unarmed", int_req, 0);

        // R3: EI enables
        ei();
        cmp("R3 int_req after EI", int_req, 1);
        rd(2'd1, v); cmp("R7 mask read with enable", v, 8'hBF);

        // R5: locked writes
        wr(2'd1, 8'h00);
        rd(2'd1, v); cmp("R5 mask write dropped", v, 8'hBF);
        cmp("R5 cfg_err set", cfg_err, 1);
        wr(2'd2, 8'h01);
        rd(2'd2, v); cmp("R5 order write dropped", v, 8'h00);

        // R9: acknowledge
        ack();
        cmp("R9 vector on ack", int_vec, 2);
        rd(2'd0, v); cmp("R9 serviced bit cleared", v, 8'h00);
        rd(2'd1, v); cmp("R9 enable dropped", v, 8'h3F);

        // R3 / R8: armed mask write enables; ascending order
        wr(2'd0, 8'h23);
        wr(2'd1, 8'hBF);
        cmp("R3 armed mask write enables", int_req, 1);
        ack();
        cmp("R8 ascending winner", int_vec, 0);
        wr(2'd2, 8'h01);
        rd(2'd2, v); cmp("R8 order accepted", v, 8'h01);
        ei();
        ack();
        cmp("R8 descending winner", int_vec, 5);

        // R9: ack without request ignored
        ack();
        cmp("R9 vec held on idle ack", int_vec, 5);
        rd(2'd0, v); cmp("R9 req untouched on idle ack", v, 8'h02);

        // R4: DI, and DI over EI
        ei();
        cmp("R4 pending before DI", int_req, 1);
        di();
        cmp("R4 DI disables", int_req, 0);
        ei_stb = 1; di_stb = 1; tick(); ei_stb = 0; di_stb = 0;
        cmp("R4 DI wins over EI", int_req, 0);

        // R7: masked level does not request
        wr(2'd1, 8'h08);
        ei();
        cmp("R7 masked level quiet", int_req, 0);

        // R10: hardware edge latency and single set
        hw_irq[3] = 1;
        tick(); tick();
        rd(2'd0, v); cmp("R10 not yet latched", v, 8'h02);
        tick();
        rd(2'd0, v); cmp("R10 latched third edge", v, 8'h0A);
        cmp("R10 hw request raises int_req", int_req, 1);
        ack();
        cmp("R10 hw level vector", int_vec, 3);
        repeat (4) tick();
        rd(2'd0, v); cmp("R10 held line sets once", v, 8'h02);

        // R11: software write and hardware set on the same edge
        hw_irq[4] = 1;
        tick(); tick();
        wr(2'd0, 8'h01);
        rd(2'd0, v); cmp("R11 write ORed with hw", v, 8'h11);
        hw_irq = '0;

        // R1: reset causes
        ei();
        do_reset(2'd2, 1'b1);
        rd(2'd1, v); cmp("R1 mask kept on SMR", v, 8'h88);
        rd(2'd2, v); cmp("R1 order kept on SMR", v, 8'h01);
        cmp("R1 err kept on SMR", cfg_err, 1);
        rd(2'd0, v); cmp("R1 req cleared on SMR", v, 8'h00);
        cmp("R1 vec cleared on SMR", int_vec, 0);
        do_reset(2'd1, 1'b0);
        rd(2'd1, v); cmp("R1 mask kept on WDT outside run", v, 8'h88);
        do_reset(2'd1, 1'b1);
        rd(2'd1, v); cmp("R1 mask cleared on WDT in run", v, 8'h00);
        cmp("R1 err cleared on WDT in run", cfg_err, 0);
        wr(2'd1, 8'h81);
        rd(2'd1, v); cmp("R2 disarmed after WDT reset", v, 8'h01);

        // mixed random traffic, compared against the model each cycle
        for (int n = 0; n < 4000; n++) begin
            ei_stb  = ($urandom % 12) == 0;
            di_stb  = ($urandom % 20) == 0;
            int_ack = ($urandom % 4) == 0;
            wr_en   = ($urandom % 5) == 0;
            wr_addr = 2'($urandom);
            wr_data = 8'($urandom);
            rd_addr = 2'($urandom);
            if (($urandom % 6) == 0) hw_irq[$urandom % 6] ^= 1'b1;
            rst_cause = 2'($urandom);
            run_mode  = 1'($urandom);
            rst_n     = ($urandom % 250) != 0;
            tick();
        end
        rst_n = 1; ei_stb = 0; di_stb = 0; int_ack = 0; wr_en = 0;
        tick(); tick();

        done = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule